// File: doc/BRIEF.md
# Pattern-Matching Wake-Up Frame Filter

This block watches received Ethernet frames, presented one byte per cycle with first-byte and last-byte flags, and decides whether a frame should wake a sleeping host. Four pattern filters run side by side on the same stream. Each filter has a 31-bit selection mask placed at a programmable byte offset. Each selected byte is folded into that filter's own CRC-16. When the last byte arrives, the result is compared with a stored signature.

A filter reports a hit only under three conditions: it is enabled, the frame's destination address type (unicast or multicast) matches its type selector, and the signature agrees. The block drives a per-filter hit vector and a wake pulse that is high when any filter hits. Software programs the filters through a flat word-wide write/read port.

Top module: `wake_pattern_filter`

## Requirements
- R1: After reset, match_vec and wake_pulse are 0 and every configuration address reads 0.
- R2: Addresses 0..3 hold the selection masks of filters 0..3. Bit 31 of a mask ignores writes and always reads 0, and bits 30:0 read back as written.
- R3: Address 4 holds the control lanes, with filter i in bits [8i+7:8i]. Bit 8i enables the filter and bit 8i+3 selects multicast (1) or unicast (0). All other bits of the word ignore writes and read 0.
- R4: Address 5 holds the byte offsets, with filter i in bits [8i+7:8i]. Address 6 holds the signatures of filters 0 (bits 15:0) and 1 (bits 31:16). Address 7 holds those of filters 2 (bits 15:0) and 3 (bits 31:16). All of these read back as written.
- R5: Frame byte number offset+j is counted from the first frame byte as 0. It enters a filter's CRC only if mask bit j is set. Bytes outside offset..offset+30, and bytes whose mask bit is clear, have no effect on the outcome. Offsets up to 255 reach byte 285.
- R6: The CRC uses polynomial x^16+x^15+x^2+1 with initial value 0xFFFF. It processes each selected byte least significant bit first. For the bytes "123456789" it gives 0x4B37.
- R7: A filter whose enable bit is 0 never reports a hit.
- R8: A frame is multicast when bit 0 of its first byte is 1, so broadcast frames count as multicast. A filter hits only on frames whose type equals its type selector.
- R9: If a frame ends before byte offset+30, the signature covers only the selected bytes that arrived.
- R10: The cycle after the last-flagged byte is accepted, match_vec shows every filter whose signature equals its stored value. wake_pulse is the OR of match_vec. Both last one cycle and are 0 at all other times.
- R11: A byte flagged as first restarts every filter's byte count and CRC, even when it directly follows the previous frame's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | rx_data carries a frame byte this cycle |
| rx_first | input | 1 | This byte is frame byte 0 |
| rx_last | input | 1 | This byte is the final frame byte |
| rx_data | input | 8 | Frame byte |
| cfg_wr | input | 1 | Write cfg_wdata to cfg_addr at the clock edge |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word at cfg_addr (combinational) |
| match_vec | output | 4 | Per-filter hit, one-cycle pulse |
| wake_pulse | output | 1 | Any filter hit, one-cycle pulse |

## Verification
A filter verdict is due exactly one clock after the edge that accepts a last-flagged byte. The driver stamps each expected hit vector with that cycle number when it presents the last byte. The monitor compares only when the cycle counter reaches the stamp, and treats any nonzero output in any other cycle as a failure. Configuration reads are combinational, so they are compared a fraction of a cycle after the address is driven, once any write has passed its clock edge.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
    localparam int BYTE_W = 8;
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    // One byte of the reflected CRC-16, bit 0 of the byte first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [BYTE_W-1:0] byte_in);
        logic [15:0] acc;
        acc = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            if (acc[0] ^ byte_in[b]) acc = (acc >> 1) ^ CRC_POLY_REFL;
            else                     acc = acc >> 1;
        end
        return acc;
    endfunction
endpackage

// File: rtl/wpf_cfg_regs.sv
module wpf_cfg_regs #(
    parameter int NF     = 4,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 8,
    parameter int CRC_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NF-1:0][DATA_W-2:0]    mask_o,
    output logic [NF-1:0][OFF_W-1:0]     off_o,
    output logic [NF-1:0]                en_o,
    output logic [NF-1:0]                mc_o,
    output logic [NF-1:0][CRC_W-1:0]     crc_o
);
    localparam int MASK_W   = DATA_W - 1;
    localparam int LANE_W   = DATA_W / NF;
    localparam int CMD_ADDR = NF;
    localparam int OFF_ADDR = NF + 1;
    localparam int SIG_ADDR = NF + 2;
    localparam int SIG_PER  = DATA_W / CRC_W;
    localparam int EN_BIT   = 0;
    localparam int MC_BIT   = 3;

    typedef struct packed {
        logic [NF-1:0][MASK_W-1:0] mask;
        logic [NF-1:0][OFF_W-1:0]  off;
        logic [NF-1:0]             en;
        logic [NF-1:0]             mc;
        logic [NF-1:0][CRC_W-1:0]  sig;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int i = 0; i < NF; i++) begin
                if (addr == ADDR_W'(i))
                    s_d.mask[i] = wdata[MASK_W-1:0];
                if (addr == ADDR_W'(CMD_ADDR)) begin
                    s_d.en[i] = wdata[i*LANE_W + EN_BIT];
                    s_d.mc[i] = wdata[i*LANE_W + MC_BIT];
                end
                if (addr == ADDR_W'(OFF_ADDR))
                    s_d.off[i] = wdata[i*LANE_W +: OFF_W];
                if (addr == ADDR_W'(SIG_ADDR + i / SIG_PER))
                    s_d.sig[i] = wdata[(i % SIG_PER)*CRC_W +: CRC_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NF; i++) begin
            if (addr == ADDR_W'(i))
                rdata = {1'b0, s_q.mask[i]};
            if (addr == ADDR_W'(CMD_ADDR)) begin
                rdata[i*LANE_W + EN_BIT] = s_q.en[i];
                rdata[i*LANE_W + MC_BIT] = s_q.mc[i];
            end
            if (addr == ADDR_W'(OFF_ADDR))
                rdata[i*LANE_W +: OFF_W] = s_q.off[i];
            if (addr == ADDR_W'(SIG_ADDR + i / SIG_PER))
                rdata[(i % SIG_PER)*CRC_W +: CRC_W] = s_q.sig[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mask_o = s_q.mask;
    assign off_o  = s_q.off;
    assign en_o   = s_q.en;
    assign mc_o   = s_q.mc;
    assign crc_o  = s_q.sig;
endmodule

// File: rtl/wpf_frame_track.sv
module wpf_frame_track #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_first,
    input  logic             group_bit,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_mcast
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             mcast;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        cur_idx   = rx_first ? '0 : s_q.idx;
        cur_mcast = rx_first ? group_bit : s_q.mcast;
        if (rx_valid) begin
            // Saturate: the count only has to reach past the last window byte.
            s_d.idx   = (&cur_idx) ? cur_idx : cur_idx + 1'b1;
            s_d.mcast = cur_mcast;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wpf_lane.sv
module wpf_lane
    import wpf_pkg::*;
#(
    parameter int MASK_W = 31,
    parameter int OFF_W  = 8,
    parameter int IDX_W  = 9,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic              rx_last,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic              cur_mcast,
    input  logic [MASK_W-1:0] sel_mask,
    input  logic [OFF_W-1:0]  sel_off,
    input  logic              enable,
    input  logic              want_mcast,
    input  logic [CRC_W-1:0]  sig_ref,
    output logic              hit_o
);
    localparam int SEL_W = $clog2(MASK_W + 1);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             hit;
    } lane_t;

    lane_t s_d, s_q;

    logic [IDX_W:0]    rel;
    logic              in_win;
    logic              take;
    logic [MASK_W:0]   mask_x;
    logic [CRC_W-1:0]  crc_base;

    always_comb begin
        s_d      = s_q;
        mask_x   = {1'b0, sel_mask};
        rel      = {1'b0, cur_idx} - (IDX_W+1)'(sel_off);
        in_win   = !rel[IDX_W] && (rel[IDX_W-1:0] < IDX_W'(MASK_W));
        take     = in_win && mask_x[rel[SEL_W-1:0]];
        crc_base = rx_first ? '1 : s_q.crc;
        s_d.hit  = 1'b0;
        if (rx_valid) begin
            s_d.crc = take ? crc16_step(crc_base, rx_data) : crc_base;
            s_d.hit = rx_last && enable && (want_mcast == cur_mcast)
                      && (s_d.crc == sig_ref);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o = s_q.hit;
endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter
    import wpf_pkg::*;
#(
    parameter int NF     = 4,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 8,
    parameter int CRC_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic              rx_last,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [NF-1:0]     match_vec,
    output logic              wake_pulse
);
    localparam int MASK_W = DATA_W - 1;
    localparam int IDX_W  = $clog2((1 << OFF_W) + MASK_W + 1);

    logic [NF-1:0][MASK_W-1:0] cfg_mask;
    logic [NF-1:0][OFF_W-1:0]  cfg_off;
    logic [NF-1:0]             cfg_en;
    logic [NF-1:0]             cfg_mc;
    logic [NF-1:0][CRC_W-1:0]  cfg_sig;
    logic [IDX_W-1:0]          frm_idx;
    logic                      frm_mcast;
    logic [NF-1:0]             lane_hit;

    wpf_cfg_regs #(
        .NF(NF), .DATA_W(DATA_W), .OFF_W(OFF_W), .CRC_W(CRC_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .mask_o (cfg_mask),
        .off_o  (cfg_off),
        .en_o   (cfg_en),
        .mc_o   (cfg_mc),
        .crc_o  (cfg_sig)
    );

    wpf_frame_track #(.IDX_W(IDX_W)) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_first  (rx_first),
        .group_bit (rx_data[0]),
        .cur_idx   (frm_idx),
        .cur_mcast (frm_mcast)
    );

    for (genvar g = 0; g < NF; g++) begin : g_lane
        wpf_lane #(
            .MASK_W(MASK_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .CRC_W(CRC_W)
        ) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_valid   (rx_valid),
            .rx_first   (rx_first),
            .rx_last    (rx_last),
            .rx_data    (rx_data),
            .cur_idx    (frm_idx),
            .cur_mcast  (frm_mcast),
            .sel_mask   (cfg_mask[g]),
            .sel_off    (cfg_off[g]),
            .enable     (cfg_en[g]),
            .want_mcast (cfg_mc[g]),
            .sig_ref    (cfg_sig[g]),
            .hit_o      (lane_hit[g])
        );
    end

    assign match_vec  = lane_hit;
    assign wake_pulse = |lane_hit;
endmodule

// File: rtl/wpf_checker.sv
module wpf_checker #(
    parameter int NF     = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_last,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [NF-1:0]     match_vec,
    input logic              wake_pulse,
    input logic [NF-1:0]     filt_en,
    input logic [NF-1:0]     filt_mc,
    input logic              frm_mcast
);
    function automatic logic [DATA_W-1:0] live_cmd_bits();
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < NF; i++) begin
            r[i*(DATA_W/NF)]     = 1'b1;
            r[i*(DATA_W/NF) + 3] = 1'b1;
        end
        return r;
    endfunction

    localparam logic [DATA_W-1:0] CMD_LIVE = live_cmd_bits();

    AST_HIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec != '0) |-> $past(rx_valid && rx_last)); // R10

    AST_WAKE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(rx_valid && rx_last)); // R10

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ~$past(filt_en)) == '0); // R7

    AST_TYPE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ($past(filt_mc) ^ {NF{$past(frm_mcast)}})) == '0); // R8

    AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr < ADDR_W'(NF)) |-> !cfg_rdata[DATA_W-1]); // R2

    AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_W'(NF)) |-> ((cfg_rdata & ~CMD_LIVE) == '0)); // R3
endmodule

bind wake_pattern_filter wpf_checker #(
    .NF(NF), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_wpf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_last    (rx_last),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .match_vec  (match_vec),
    .wake_pulse (wake_pulse),
    .filt_en    (cfg_en),
    .filt_mc    (cfg_mc),
    .frm_mcast  (frm_mcast)
);

// File: tb/test_wake_pattern_filter.sv
`timescale 1ns/1ps
module test_wake_pattern_filter;
    localparam int FR_MAX = 400;
    typedef logic [7:0] frame_t [0:FR_MAX-1];
    typedef struct {
        int         due;
        logic [3:0] vec;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  match_vec;
    logic        wake_pulse;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;
    exp_t sb[$];

    logic [30:0] m_mask [4];
    logic [7:0]  m_off  [4];
    logic        m_en   [4];
    logic        m_mc   [4];
    logic [15:0] m_sig  [4];

    frame_t fa, fb, fc;

    wake_pattern_filter i_wake_pattern_filter (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_last(rx_last), .rx_data(rx_data), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .match_vec(match_vec),
        .wake_pulse(wake_pulse)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Spec CRC: x^16+x^15+x^2+1, reflected, init all ones, LSB of each byte first.
    function automatic logic [15:0] ref_crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb_bit;
            fb_bit = r[0] ^ d[b];
            r = {1'b0, r[15:1]};
            if (fb_bit) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic logic [15:0] sig_of(input int f, input frame_t fr, input int len);
        logic [15:0] c = 16'hFFFF;
        for (int j = 0; j < 31; j++) begin
            int p;
            p = int'(m_off[f]) + j;
            if (m_mask[f][j] && p < len) c = ref_crc_byte(c, fr[p]);
        end
        return c;
    endfunction

    task automatic fill(output frame_t fr, input int seed, input logic [7:0] b0);
        for (int p = 0; p < FR_MAX; p++) fr[p] = 8'((p * 37 + seed * 11 + (p >> 3)) ^ seed);
        fr[0] = b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata === exp, req, $sformatf("read addr %0d", a), cfg_rdata, exp);
    endtask

    task automatic set_filter(input int f, input logic [30:0] mk, input logic [7:0] off,
                              input logic en, input logic mc, input logic [15:0] sig);
        logic [31:0] cmdw, offw, sigw;
        m_mask[f] = mk; m_off[f] = off; m_en[f] = en; m_mc[f] = mc; m_sig[f] = sig;
        cmdw = '0; offw = '0;
        for (int i = 0; i < 4; i++) begin
            cmdw[i*8]     = m_en[i];
            cmdw[i*8 + 3] = m_mc[i];
            offw[i*8 +: 8] = m_off[i];
        end
        sigw = (f < 2) ? {m_sig[1], m_sig[0]} : {m_sig[3], m_sig[2]};
        wr(3'(f), {1'b0, mk});
        wr(3'd4, cmdw);
        wr(3'd5, offw);
        wr((f < 2) ? 3'd6 : 3'd7, sigw);
    endtask

    // Driver: streams the frame and queues the verdict due one cycle after the last byte.
    task automatic send(input frame_t fr, input int len, input bit gap,
                        input logic [3:0] exp_vec, input string tag);
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = (p == 0); rx_last = (p == len - 1); rx_data = fr[p];
            if (p == len - 1) sb.push_back('{cyc + 1, exp_vec, tag});
        end
        if (gap) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_data = '0;
        end
    endtask

    // Monitor: compares at the due cycle, flags any output outside it.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t it;
                it = sb.pop_front();
                chk(match_vec === it.vec, it.tag, "match_vec", 32'(match_vec), 32'(it.vec));
                chk(wake_pulse === (it.vec != 4'd0), "R10", "wake_pulse",
                    32'(wake_pulse), 32'(it.vec != 4'd0));
            end else if (wake_pulse !== 1'b0 || match_vec !== 4'd0) begin
                chk(1'b0, "R10", "output outside verdict cycle",
                    {27'd0, wake_pulse, match_vec}, 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_mask[i] = '0; m_off[i] = '0; m_en[i] = 1'b0; m_mc[i] = 1'b0; m_sig[i] = '0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(match_vec === 4'd0, "R1", "match_vec in reset", 32'(match_vec), 32'd0);
        chk(wake_pulse === 1'b0, "R1", "wake_pulse in reset", 32'(wake_pulse), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'd0, "R1");

        // Register map: R2 R3 R4
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'h7FFF_FFFF, "R2");
        wr(3'd2, 32'h8123_4567);
        rd_chk(3'd2, 32'h0123_4567, "R2");
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk(3'd4, 32'h0909_0909, "R3");
        wr(3'd5, 32'h1234_5678);
        rd_chk(3'd5, 32'h1234_5678, "R4");
        wr(3'd6, 32'hBEEF_1234);
        wr(3'd7, 32'hCAFE_5678);
        rd_chk(3'd6, 32'hBEEF_1234, "R4");
        rd_chk(3'd7, 32'hCAFE_5678, "R4");

        // R6: known check value over "123456789" (first byte 0x31 is multicast)
        for (int i = 1; i < 4; i++) set_filter(i, '0, '0, 1'b0, 1'b0, '0);
        set_filter(0, 31'h1FF, 8'd0, 1'b1, 1'b1, 16'h4B37);
        fc = '{default: 8'h00};
        for (int p = 0; p < 9; p++) fc[p] = 8'(8'h31 + p);
        send(fc, 9, 1'b1, 4'b0001, "R6");

        // R7 R8: unicast frame, four differently gated filters
        fill(fa, 3, 8'h02);
        m_mask[0] = 31'h05A5_A5A5; m_off[0] = 8'd12;
        set_filter(0, 31'h05A5_A5A5, 8'd12, 1'b1, 1'b0, sig_of(0, fa, 64));
        set_filter(1, 31'h05A5_A5A5, 8'd12, 1'b1, 1'b1, sig_of(0, fa, 64));
        set_filter(2, 31'h05A5_A5A5, 8'd12, 1'b0, 1'b0, sig_of(0, fa, 64));
        set_filter(3, 31'h05A5_A5A5, 8'd12, 1'b1, 1'b0, sig_of(0, fa, 64) ^ 16'h0001);
        send(fa, 64, 1'b1, 4'b0001, "R7 R8");

        // R5: unselected and out-of-window bytes do not matter, selected ones do
        fb = fa; fb[13] = ~fb[13]; fb[5] = ~fb[5]; fb[50] = ~fb[50];
        send(fb, 64, 1'b1, 4'b0001, "R5 skipped bytes");
        fb = fa; fb[12] = ~fb[12];
        send(fb, 64, 1'b1, 4'b0000, "R5 selected byte");

        // R8: multicast and broadcast frames go to the multicast filter only
        fill(fb, 9, 8'h01);
        m_mask[1] = 31'h05A5_A5A5; m_off[1] = 8'd12;
        set_filter(1, 31'h05A5_A5A5, 8'd12, 1'b1, 1'b1, sig_of(1, fb, 64));
        set_filter(0, 31'h05A5_A5A5, 8'd12, 1'b1, 1'b0, sig_of(1, fb, 64));
        send(fb, 64, 1'b1, 4'b0010, "R8 multicast");
        fb[0] = 8'hFF;
        send(fb, 64, 1'b1, 4'b0010, "R8 broadcast");

        // R9: frame ends inside the window
        set_filter(0, 31'h05A5_A5A5, 8'd12, 1'b1, 1'b0, sig_of(0, fa, 64));
        m_mask[2] = 31'h7FFF_FFFF; m_off[2] = 8'd20;
        set_filter(2, 31'h7FFF_FFFF, 8'd20, 1'b1, 1'b0, sig_of(2, fa, 30));
        send(fa, 30, 1'b1, 4'b0100, "R9");

        // R11: back-to-back frames with no idle cycle between them
        send(fa, 30, 1'b0, 4'b0100, "R11 first");
        send(fa, 64, 1'b0, 4'b0001, "R11 second");
        send(fa, 30, 1'b1, 4'b0100, "R11 third");

        // R10: all four filters hit together
        m_mask[0] = 31'h0000_000F; m_off[0] = 8'd0;
        set_filter(0, 31'h0000_000F, 8'd0, 1'b1, 1'b0, sig_of(0, fa, 64));
        m_mask[1] = 31'h7000_0001; m_off[1] = 8'd6;
        set_filter(1, 31'h7000_0001, 8'd6, 1'b1, 1'b0, sig_of(1, fa, 64));
        m_mask[2] = 31'h1234_5678; m_off[2] = 8'd30;
        set_filter(2, 31'h1234_5678, 8'd30, 1'b1, 1'b0, sig_of(2, fa, 64));
        m_mask[3] = 31'h0F0F_0F0F; m_off[3] = 8'd25;
        set_filter(3, 31'h0F0F_0F0F, 8'd25, 1'b1, 1'b0, sig_of(3, fa, 64));
        send(fa, 64, 1'b1, 4'b1111, "R10 all hit");

        // R5: far offset reaches byte 280 of a long frame
        m_mask[3] = 31'h4000_0000; m_off[3] = 8'd250;
        set_filter(3, 31'h4000_0000, 8'd250, 1'b1, 1'b0, sig_of(3, fa, 300));
        send(fa, 300, 1'b1, 4'b1111, "R5 far offset");
        fb = fa; fb[280] = ~fb[280];
        send(fb, 300, 1'b1, 4'b0111, "R5 far byte changed");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R10", "verdicts outstanding", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule